// File: doc/BRIEF.md
# Delayed Lockstep Equivalence Checker

This block sits between a main processor core and a shadow core that runs a fixed number of cycles behind it. Every input the main core receives, including read data from its tightly coupled memories and its instruction-cache inputs, goes through a delay line. The delayed copy is handed to the shadow core, which never touches those memories itself. The main core's outputs and its monitored register values are packed into one vector. That vector goes through a second delay line of the same length, and each cycle the delayed vector is compared with the matching vector from the shadow core.

Comparison stays masked until the pipelines have filled after reset. Checking is switched off for good, until the next reset, once debug mode is seen. On any difference the block raises a sticky panic and detection flag, then reacts according to a runtime-selected policy:

- **Report:** let the cores run on.
- **Interrupt:** request an interrupt and hold a halt until acknowledged.
- **Escalate:** escalate to an external controller and hold the request until reset.

Top module: `lockstep_checker`

## Requirements
- R1: While rst_ni is low and immediately after its release, panic_o, detect_o, irq_o, halt_o and escalate_o are 0 and shadow_in_o is all zeros.
- R2: shadow_in_o equals the value main_in_i had exactly DELAY clock edges earlier (legal DELAY values are 2, 3 and 4); for the first DELAY edges after reset it reads zero.
- R3: Once armed, the two vectors are compared at each clock edge: main_cmp_i as sampled DELAY edges earlier, and shadow_cmp_i as sampled now. If they differ in any single bit, panic_o and detect_o go to 1 after that edge. If they are equal, no panic results.
- R4: At the first DELAY clock edges after reset, differences are ignored, and panic_o stays 0.
- R5: panic_o and detect_o, once set, stay 1 until reset in every policy, including after irq_ack_i.
- R6: A difference present at any edge where debug_mode_i is 1 is ignored. A difference at any later edge before the next reset is also ignored, even after debug_mode_i returns to 0.
- R7: With policy_i = 1 (interrupt), irq_o is 1 for exactly the cycle after each mismatching edge. halt_o goes to 1 after the first mismatching edge and returns to 0 after an edge where irq_ack_i is 1 and no new mismatch occurs. detect_o remains 1.
- R8: With policy_i = 2 (escalate), escalate_o goes to 1 after a mismatching edge and stays 1 until reset; irq_ack_i has no effect on it.
- R9: With policy_i = 0 (report), a mismatch leaves irq_o, halt_o and escalate_o at 0. The unused code policy_i = 3 behaves like code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Error policy: 0 report, 1 interrupt/halt, 2 escalate, 3 treated as 2 |
| debug_mode_i | input | 1 | Main core is in debug mode; disables checking until reset |
| irq_ack_i | input | 1 | Interrupt handled; releases halt_o |
| main_in_i | input | IN_W | Inputs of the main core |
| shadow_in_o | output | IN_W | Main core inputs delayed by DELAY cycles, for the shadow core |
| main_cmp_i | input | CMP_W | Concatenated main core outputs and monitored registers |
| shadow_cmp_i | input | CMP_W | Matching vector from the shadow core |
| panic_o | output | 1 | Sticky mismatch panic |
| detect_o | output | 1 | Sticky detection bit |
| irq_o | output | 1 | One-cycle interrupt request per mismatching cycle (policy 1) |
| halt_o | output | 1 | Core halt until acknowledge (policy 1) |
| escalate_o | output | 1 | Held escalation request to external controller (policies 2, 3) |

## Verification
The bench builds the block with DELAY = 4, the largest legal lag, IN_W = 16 and CMP_W = 32. With the largest lag, the masked fill window and the alignment of every delay stage are at their longest. Single-bit corruptions at both ends and in the middle of the compared vector are then reachable for all four policy codes. A scoreboard predicts the shadow-core input stream from the bench's own history of main inputs. Directed sequences cover the first armed cycle, a debug-mode entry in the same cycle as a difference and on an earlier cycle, and the acknowledge.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  typedef enum logic [1:0] {
    POL_REPORT   = 2'd0,
    POL_IRQ      = 2'd1,
    POL_ESCALATE = 2'd2,
    POL_RSVD     = 2'd3
  } err_policy_e;
endpackage

// File: rtl/ls_delay_line.sv
module ls_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/ls_arm_ctrl.sv
module ls_arm_ctrl #(
  parameter int DELAY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic debug_mode_i,
  output logic armed_o
);
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DELAY);

  logic [CNT_W-1:0] fill_q;
  logic             dbg_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q    <= '0;
      dbg_off_q <= 1'b0;
    end else begin
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
      if (debug_mode_i)   dbg_off_q <= 1'b1;
    end
  end

  // debug entry masks its own cycle too
  assign armed_o = (fill_q == FULL) && !dbg_off_q && !debug_mode_i;
endmodule

// File: rtl/ls_policy_ctrl.sv
module ls_policy_ctrl
  import lockstep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mismatch_i,
  input  logic [1:0] policy_i,
  input  logic       irq_ack_i,
  output logic       flag_o,
  output logic       irq_o,
  output logic       halt_o,
  output logic       escalate_o
);
  err_policy_e pol;
  logic        hit_irq, hit_esc;
  logic        flag_q, irq_q, halt_q, esc_q;

  assign pol     = err_policy_e'(policy_i);
  assign hit_irq = mismatch_i && (pol == POL_IRQ);
  assign hit_esc = mismatch_i && (pol == POL_ESCALATE || pol == POL_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
      esc_q  <= 1'b0;
    end else begin
      if (mismatch_i) flag_q <= 1'b1;
      irq_q <= hit_irq;
      if (hit_irq)        halt_q <= 1'b1;
      else if (irq_ack_i) halt_q <= 1'b0;
      if (hit_esc) esc_q <= 1'b1;
    end
  end

  assign flag_o     = flag_q;
  assign irq_o      = irq_q;
  assign halt_o     = halt_q;
  assign escalate_o = esc_q;
endmodule

// File: rtl/lockstep_checker.sv
module lockstep_checker #(
  parameter int DELAY = 3,
  parameter int IN_W  = 64,
  parameter int CMP_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       policy_i,
  input  logic             debug_mode_i,
  input  logic             irq_ack_i,
  input  logic [IN_W-1:0]  main_in_i,
  output logic [IN_W-1:0]  shadow_in_o,
  input  logic [CMP_W-1:0] main_cmp_i,
  input  logic [CMP_W-1:0] shadow_cmp_i,
  output logic             panic_o,
  output logic             detect_o,
  output logic             irq_o,
  output logic             halt_o,
  output logic             escalate_o
);
  logic [CMP_W-1:0] main_cmp_dly;
  logic             armed, mismatch, flag;

  ls_delay_line #(.W(IN_W), .DEPTH(DELAY)) u_in_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (main_in_i),
    .q_o   (shadow_in_o)
  );

  ls_delay_line #(.W(CMP_W), .DEPTH(DELAY)) u_cmp_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (main_cmp_i),
    .q_o   (main_cmp_dly)
  );

  ls_arm_ctrl #(.DELAY(DELAY)) u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .debug_mode_i(debug_mode_i),
    .armed_o     (armed)
  );

  assign mismatch = armed && (main_cmp_dly != shadow_cmp_i);

  ls_policy_ctrl u_pol (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mismatch_i(mismatch),
    .policy_i  (policy_i),
    .irq_ack_i (irq_ack_i),
    .flag_o    (flag),
    .irq_o     (irq_o),
    .halt_o    (halt_o),
    .escalate_o(escalate_o)
  );

  assign panic_o  = flag;
  assign detect_o = flag;
endmodule

// File: rtl/lockstep_checker_sva.sv
module lockstep_checker_sva #(
  parameter int DELAY = 3,
  parameter int IN_W  = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      policy_i,
  input logic            debug_mode_i,
  input logic [IN_W-1:0] main_in_i,
  input logic [IN_W-1:0] shadow_in_o,
  input logic            panic_o,
  input logic            irq_o,
  input logic            halt_o,
  input logic            escalate_o
);
  localparam int CW = $clog2(DELAY + 2) + 1;
  localparam logic [CW-1:0] LIM = CW'(DELAY + 1);

  logic [CW-1:0] edges_q;
  logic          dbg_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edges_q    <= '0;
      dbg_seen_q <= 1'b0;
    end else begin
      if (edges_q != LIM) edges_q <= edges_q + 1'b1;
      if (debug_mode_i)   dbg_seen_q <= 1'b1;
    end
  end

  AST_SHADOW_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q >= CW'(DELAY)) |-> (shadow_in_o == $past(main_in_i, DELAY))); // R2

  AST_NO_PANIC_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q <= CW'(DELAY)) |-> !panic_o); // R4

  AST_PANIC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panic_o |=> panic_o); // R5

  AST_DEBUG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_seen_q && !panic_o) |=> !panic_o); // R6

  AST_IRQ_WITH_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> halt_o); // R7

  AST_HALT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> ($past(policy_i) == 2'd1)); // R7

  AST_ESC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    escalate_o |=> escalate_o); // R8
endmodule

bind lockstep_checker lockstep_checker_sva #(.DELAY(DELAY), .IN_W(IN_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .policy_i    (policy_i),
  .debug_mode_i(debug_mode_i),
  .main_in_i   (main_in_i),
  .shadow_in_o (shadow_in_o),
  .panic_o     (panic_o),
  .irq_o       (irq_o),
  .halt_o      (halt_o),
  .escalate_o  (escalate_o)
);

// File: tb/lockstep_checker_tb_top.sv
`timescale 1ns/1ps
module lockstep_checker_tb_top;
  localparam int D     = 4;
  localparam int IN_W  = 16;
  localparam int CMP_W = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       policy = 2'd0;
  logic             dbg = 1'b0;
  logic             ack = 1'b0;
  logic [IN_W-1:0]  main_in = '0;
  logic [IN_W-1:0]  shadow_in;
  logic [CMP_W-1:0] main_cmp = '0;
  logic [CMP_W-1:0] shadow_cmp = '0;
  logic             panic, detect, irq, halt, esc;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  logic [IN_W-1:0]  sb_q [$];
  logic [CMP_W-1:0] hist [D];

  lockstep_checker #(.DELAY(D), .IN_W(IN_W), .CMP_W(CMP_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .policy_i    (policy),
    .debug_mode_i(dbg),
    .irq_ack_i   (ack),
    .main_in_i   (main_in),
    .shadow_in_o (shadow_in),
    .main_cmp_i  (main_cmp),
    .shadow_cmp_i(shadow_cmp),
    .panic_o     (panic),
    .detect_o    (detect),
    .irq_o       (irq),
    .halt_o      (halt),
    .escalate_o  (esc)
  );

  initial forever #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: predicted shadow input stream
  always @(negedge clk) begin
    if (mon_en) begin
      while (sb_q.size() > D) begin
        logic [IN_W-1:0] e;
        e = sb_q.pop_front();
        chk("R2 shadow_in", 64'(shadow_in), 64'(e));
      end
    end
  end

  task automatic do_reset(input logic [1:0] pol);
    mon_en   = 1'b0;
    rst_ni   = 1'b0;
    policy   = pol;
    dbg      = 1'b0;
    ack      = 1'b0;
    main_in  = '0;
    main_cmp = '0;
    shadow_cmp = '0;
    sb_q.delete();
    for (int i = 0; i < D; i++) hist[i] = '0;
    repeat (2) @(posedge clk);
    chk("R1 panic in reset", 64'(panic), 64'd0);
    chk("R1 shadow_in in reset", 64'(shadow_in), 64'd0);
    #1 rst_ni = 1'b1;
    chk("R1 outs after reset", 64'({panic, detect, irq, halt, esc}), 64'd0);
    for (int i = 0; i < D; i++) sb_q.push_back('0);
    mon_en = 1'b1;
  endtask

  // driver: one cycle of stimulus; flip corrupts the shadow vector
  task automatic step(input logic [CMP_W-1:0] flip);
    main_in    = IN_W'($urandom);
    main_cmp   = CMP_W'($urandom);
    shadow_cmp = hist[D-1] ^ flip;
    for (int i = D - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = main_cmp;
    sb_q.push_back(main_in);
    @(posedge clk);
    #1;
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) step('0);
  endtask

  initial begin
    // report policy, long clean run
    do_reset(2'd0);
    clean(60);
    chk("R3 no panic when equal", 64'(panic), 64'd0);

    // fill window ignored
    do_reset(2'd0);
    for (int i = 0; i < D; i++) step(32'h1);
    clean(5);
    chk("R4 fill masked", 64'(panic), 64'd0);

    // first armed edge, several bit positions
    for (int b = 0; b < CMP_W; b += 15) begin
      do_reset(2'd0);
      clean(D);
      step(CMP_W'(1) << b);
      chk($sformatf("R3 bit %0d panic", b), 64'(panic), 64'd1);
      chk("R3 detect", 64'(detect), 64'd1);
      chk("R9 report quiet", 64'({irq, halt, esc}), 64'd0);
    end
    do_reset(2'd0);
    clean(D + 3);
    step(32'h8000_0000);
    clean(10);
    chk("R5 sticky panic", 64'({panic, detect}), 64'h3);
    chk("R9 report stays quiet", 64'({irq, halt, esc}), 64'd0);

    // interrupt policy
    do_reset(2'd1);
    clean(8);
    step(32'h0001_0000);
    chk("R7 irq pulse", 64'(irq), 64'd1);
    chk("R7 halt set", 64'(halt), 64'd1);
    clean(1);
    chk("R7 irq one cycle", 64'(irq), 64'd0);
    clean(4);
    chk("R7 halt held", 64'(halt), 64'd1);
    ack = 1'b1;
    clean(1);
    ack = 1'b0;
    chk("R7 halt released", 64'(halt), 64'd0);
    chk("R7 detect kept", 64'(detect), 64'd1);
    chk("R5 panic after ack", 64'(panic), 64'd1);
    chk("R7 no escalate", 64'(esc), 64'd0);

    // escalate policy
    do_reset(2'd2);
    clean(7);
    step(32'h0000_0100);
    chk("R8 escalate set", 64'(esc), 64'd1);
    chk("R8 no halt", 64'({irq, halt}), 64'd0);
    ack = 1'b1;
    clean(3);
    ack = 1'b0;
    clean(6);
    chk("R8 escalate held", 64'(esc), 64'd1);
    do_reset(2'd2);
    chk("R8 cleared by reset", 64'(esc), 64'd0);

    // reserved code
    do_reset(2'd3);
    clean(6);
    step(32'h4);
    chk("R9 code 3 escalates", 64'(esc), 64'd1);
    chk("R9 code 3 no halt", 64'(halt), 64'd0);

    // debug mode on an earlier cycle
    do_reset(2'd2);
    clean(6);
    dbg = 1'b1;
    clean(1);
    dbg = 1'b0;
    clean(3);
    step(32'h2);
    clean(3);
    chk("R6 disabled after debug", 64'({panic, esc}), 64'd0);

    // debug mode in the same cycle as a difference
    do_reset(2'd0);
    clean(6);
    dbg = 1'b1;
    step(32'h10);
    dbg = 1'b0;
    step(32'h20);
    clean(2);
    chk("R6 same-cycle debug", 64'(panic), 64'd0);

    clean(D + 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule